// File: doc/BRIEF.md
# Memory Device Boundary-Scan Test Port

This block is the serial test port of a memory device. A tester drives the test clock, mode select and serial data input. The block steps a sixteen-state controller, holds a three-bit instruction, and routes one of three data registers between the serial input and the serial output. The three registers are a one-bit bypass stage, a 32-bit identification word and a boundary-scan chain that captures the parallel pad input vector. There is no dedicated test reset pin. The controller starts from the device's power-on reset, and it can be brought back to its reset state at any time by holding mode select high for five clocks.

Two of the scan instructions also raise a control that puts the memory data pins into high impedance, so that the values seen on those pins come only from the outside. Plain sampling leaves the pins driven. The port only observes the pads and never drives internal data out. The serial output is enabled only while a register is being shifted, and it changes on the falling test clock edge. Mode select and serial data are expected to have pull-ups on the board, so that a floating input reads as 1 and keeps the controller in reset.

Top module: `sram_tap`

## Requirements
- R1: The controller has sixteen states: reset, idle, and for each of the DR and IR columns a select, capture, shift, exit1, pause, exit2 and update state. It moves on the mode-select value sampled at each rising test clock edge, following the standard 1149.1 transition graph, including the pause and exit2 loops.
- R2: Power-on reset puts the controller in the reset state with the IDCODE instruction active. Five consecutive rising edges with mode select high return it to the reset state from any state, and the reset state loads IDCODE again.
- R3: The instruction is 3 bits wide. Capture-IR loads binary 001 into the instruction shift stage. Shift-IR shifts the serial input into bit 2 and shifts bit 0 out. The shifted value becomes the active instruction only at Update-IR.
- R4: The codes select data registers as follows. 000 (EXTEST), 010 (SAMPLE-Z) and 100 (SAMPLE) select the boundary chain, which loads the pad input vector at Capture-DR, bit 0 first out. 001 (IDCODE) selects the identification register. 111 (BYPASS) and the reserved codes 011, 101 and 110 select the bypass stage.
- R5: The data-pin high-impedance output is 1 exactly while the active instruction is 000 or 010. It is 0 for SAMPLE, IDCODE, BYPASS and the reserved codes.
- R6: The bypass stage loads 0 at Capture-DR. In Shift-DR it delays the serial input by one clock, and it keeps its last bit through Exit1, Pause and Exit2.
- R7: The identification register captures the 32-bit ID parameter, whose bit 0 is 1, and shifts it out bit 0 first. The serial input enters at bit 31, so external data follows the ID word out.
- R8: The serial output and its enable change only on the falling test clock edge. The enable is 1 only in Shift-DR and Shift-IR, and the output then carries bit 0 of the selected register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| tck | input | 1 | Test clock |
| por_n | input | 1 | Device power-on reset, active low |
| tms | input | 1 | Test mode select |
| tdi | input | 1 | Serial data input |
| pad_in | input | BSR_W | Parallel pad values observed by the boundary chain |
| tdo | output | 1 | Serial data output, high impedance when not enabled |
| tdo_oe | output | 1 | Serial output enable |
| dq_hiz | output | 1 | Places the memory data pins in high impedance |

## Verification
The assertions check on every cycle that five high mode-select samples land in the reset state. They also check that a shift state holds while mode select is low, that Capture-IR leaves 001 in the shift stage, and that the instruction stays unchanged outside Update-IR and reset. Further checks cover the one-clock delay of the bypass stage, that the output enable appears only in shift states, and that the pin high-impedance control occurs only with the boundary chain selected. The bench's scenarios cover the rest: the mapping of each of the eight codes to a register and a pin state, the pad values and ID word arriving at the serial output in order, the bypass bit kept across a pause, and the instruction falling back to IDCODE after the five-clock escape.

// File: rtl/sram_tap_pkg.sv
package sram_tap_pkg;

  typedef enum logic [3:0] {
    TS_RESET, TS_IDLE,
    TS_DR_SEL, TS_DR_CAP, TS_DR_SHIFT, TS_DR_EXIT1, TS_DR_PAUSE, TS_DR_EXIT2, TS_DR_UPD,
    TS_IR_SEL, TS_IR_CAP, TS_IR_SHIFT, TS_IR_EXIT1, TS_IR_PAUSE, TS_IR_EXIT2, TS_IR_UPD
  } tap_state_e;

  localparam int OPC_W = 3;
  localparam logic [OPC_W-1:0] OPC_EXTEST  = 3'b000;
  localparam logic [OPC_W-1:0] OPC_IDCODE  = 3'b001;
  localparam logic [OPC_W-1:0] OPC_SAMPZ   = 3'b010;
  localparam logic [OPC_W-1:0] OPC_SAMPLE  = 3'b100;
  localparam logic [OPC_W-1:0] OPC_BYPASS  = 3'b111;
  localparam logic [OPC_W-1:0] OPC_CAPTURE = 3'b001;

  typedef enum logic [1:0] {PATH_BSR, PATH_ID, PATH_BYP} dr_path_e;

  function automatic dr_path_e path_of(input logic [OPC_W-1:0] opc);
    case (opc)
      OPC_EXTEST, OPC_SAMPZ, OPC_SAMPLE: path_of = PATH_BSR;
      OPC_IDCODE:                        path_of = PATH_ID;
      default:                           path_of = PATH_BYP;
    endcase
  endfunction

  function automatic logic hiz_of(input logic [OPC_W-1:0] opc);
    hiz_of = (opc == OPC_EXTEST) || (opc == OPC_SAMPZ);
  endfunction

endpackage

// File: rtl/sram_tap_fsm.sv
module sram_tap_fsm
  import sram_tap_pkg::*;
(
  input  logic       tck,
  input  logic       rst_n,
  input  logic       tms,
  output tap_state_e state
);

  tap_state_e state_d;

  always_comb begin
    state_d = state;
    case (state)
      TS_RESET:    state_d = tms ? TS_RESET    : TS_IDLE;
      TS_IDLE:     state_d = tms ? TS_DR_SEL   : TS_IDLE;
      TS_DR_SEL:   state_d = tms ? TS_IR_SEL   : TS_DR_CAP;
      TS_DR_CAP:   state_d = tms ? TS_DR_EXIT1 : TS_DR_SHIFT;
      TS_DR_SHIFT: state_d = tms ? TS_DR_EXIT1 : TS_DR_SHIFT;
      TS_DR_EXIT1: state_d = tms ? TS_DR_UPD   : TS_DR_PAUSE;
      TS_DR_PAUSE: state_d = tms ? TS_DR_EXIT2 : TS_DR_PAUSE;
      TS_DR_EXIT2: state_d = tms ? TS_DR_UPD   : TS_DR_SHIFT;
      TS_DR_UPD:   state_d = tms ? TS_DR_SEL   : TS_IDLE;
      TS_IR_SEL:   state_d = tms ? TS_RESET    : TS_IR_CAP;
      TS_IR_CAP:   state_d = tms ? TS_IR_EXIT1 : TS_IR_SHIFT;
      TS_IR_SHIFT: state_d = tms ? TS_IR_EXIT1 : TS_IR_SHIFT;
      TS_IR_EXIT1: state_d = tms ? TS_IR_UPD   : TS_IR_PAUSE;
      TS_IR_PAUSE: state_d = tms ? TS_IR_EXIT2 : TS_IR_PAUSE;
      TS_IR_EXIT2: state_d = tms ? TS_IR_UPD   : TS_IR_SHIFT;
      TS_IR_UPD:   state_d = tms ? TS_DR_SEL   : TS_IDLE;
      default:     state_d = TS_RESET;
    endcase
  end

  always_ff @(posedge tck or negedge rst_n) begin
    if (!rst_n) state <= TS_RESET;
    else        state <= state_d;
  end

  // R2: five high mode-select samples always end in the reset state
  assert_five_high_reset_R2: assert property (@(posedge tck) disable iff (!rst_n)
    (tms && $past(tms) && $past(tms, 2) && $past(tms, 3) && $past(tms, 4))
    |=> state == TS_RESET);

  // R1: a shift state is held while mode select stays low
  assert_shift_hold_R1: assert property (@(posedge tck) disable iff (!rst_n)
    ((state == TS_DR_SHIFT || state == TS_IR_SHIFT) && !tms) |=> $stable(state));

endmodule

// File: rtl/sram_tap_ir.sv
module sram_tap_ir
  import sram_tap_pkg::*;
(
  input  logic       tck,
  input  logic       rst_n,
  input  tap_state_e state,
  input  logic       tdi,
  output logic       ir_so,
  output dr_path_e   path,
  output logic       dq_hiz,
  output logic       byp_clr
);

  logic [OPC_W-1:0] ir_sh, ir_sh_d;
  logic [OPC_W-1:0] ir_q, ir_d;
  logic             ir_sh_en, ir_en;

  always_comb begin
    ir_sh_en = (state == TS_IR_CAP) || (state == TS_IR_SHIFT);
    ir_sh_d  = (state == TS_IR_CAP) ? OPC_CAPTURE : {tdi, ir_sh[OPC_W-1:1]};
    ir_en    = (state == TS_IR_UPD) || (state == TS_RESET);
    ir_d     = (state == TS_RESET) ? OPC_IDCODE : ir_sh;
  end

  always_ff @(posedge tck) begin
    if (ir_sh_en) ir_sh <= ir_sh_d;
  end

  always_ff @(posedge tck or negedge rst_n) begin
    if (!rst_n)     ir_q <= OPC_IDCODE;
    else if (ir_en) ir_q <= ir_d;
  end

  assign ir_so   = ir_sh[0];
  assign path    = path_of(ir_q);
  assign dq_hiz  = hiz_of(ir_q);
  assign byp_clr = (state == TS_IR_UPD) && (path_of(ir_sh) == PATH_BYP);

  // R3: capture leaves the fixed pattern in the shift stage
  assert_capture_pattern_R3: assert property (@(posedge tck) disable iff (!rst_n)
    (state == TS_IR_CAP) |=> ir_sh == OPC_CAPTURE);

  // R3: the active instruction only changes at Update-IR or in reset
  assert_ir_stable_R3: assert property (@(posedge tck) disable iff (!rst_n)
    (state != TS_IR_UPD && state != TS_RESET) |=> $stable(ir_q));

endmodule

// File: rtl/sram_tap_dr.sv
module sram_tap_dr
  import sram_tap_pkg::*;
#(
  parameter int          BSR_W    = 8,
  parameter logic [31:0] ID_VALUE = 32'h5A3C_10E1
) (
  input  logic             tck,
  input  logic             rst_n,
  input  tap_state_e       state,
  input  dr_path_e         path,
  input  logic             byp_clr,
  input  logic             tdi,
  input  logic [BSR_W-1:0] pad_in,
  output logic             dr_so
);

  localparam int ID_W = 32;

  logic [BSR_W-1:0] bsr_q;
  logic [ID_W-1:0]  id_q;
  logic             byp_q;
  logic             cap, sft;

  assign cap = (state == TS_DR_CAP);
  assign sft = (state == TS_DR_SHIFT);

  always_ff @(posedge tck) begin
    if (path == PATH_BSR && (cap || sft))
      bsr_q <= cap ? pad_in : {tdi, bsr_q[BSR_W-1:1]};
  end

  always_ff @(posedge tck) begin
    if (path == PATH_ID && (cap || sft))
      id_q <= cap ? ID_VALUE : {tdi, id_q[ID_W-1:1]};
  end

  always_ff @(posedge tck or negedge rst_n) begin
    if (!rst_n)                                  byp_q <= 1'b0;
    else if (byp_clr || (path == PATH_BYP && cap)) byp_q <= 1'b0;
    else if (path == PATH_BYP && sft)            byp_q <= tdi;
  end

  always_comb begin
    case (path)
      PATH_BSR: dr_so = bsr_q[0];
      PATH_ID:  dr_so = id_q[0];
      default:  dr_so = byp_q;
    endcase
  end

  // R6: bypass stage delays the serial input by exactly one clock
  assert_bypass_delay_R6: assert property (@(posedge tck) disable iff (!rst_n)
    (sft && path == PATH_BYP) |=> byp_q == $past(tdi));

  // R6: bypass stage loads zero at capture
  assert_bypass_capture_R6: assert property (@(posedge tck) disable iff (!rst_n)
    (cap && path == PATH_BYP) |=> !byp_q);

endmodule

// File: rtl/sram_tap.sv
module sram_tap
  import sram_tap_pkg::*;
#(
  parameter int          BSR_W    = 8,
  parameter logic [31:0] ID_VALUE = 32'h5A3C_10E1
) (
  input  logic             tck,
  input  logic             por_n,
  input  logic             tms,
  input  logic             tdi,
  input  logic [BSR_W-1:0] pad_in,
  output logic             tdo,
  output logic             tdo_oe,
  output logic             dq_hiz
);

  logic [1:0] rst_sync;
  logic       rst_n;
  tap_state_e state;
  dr_path_e   path;
  logic       ir_so, dr_so, byp_clr, tdo_q, so_sel, oe_d;

  always_ff @(posedge tck or negedge por_n) begin
    if (!por_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_n = rst_sync[1];

  sram_tap_fsm u_fsm (
    .tck   (tck),
    .rst_n (rst_n),
    .tms   (tms),
    .state (state)
  );

  sram_tap_ir u_ir (
    .tck     (tck),
    .rst_n   (rst_n),
    .state   (state),
    .tdi     (tdi),
    .ir_so   (ir_so),
    .path    (path),
    .dq_hiz  (dq_hiz),
    .byp_clr (byp_clr)
  );

  sram_tap_dr #(.BSR_W(BSR_W), .ID_VALUE(ID_VALUE)) u_dr (
    .tck     (tck),
    .rst_n   (rst_n),
    .state   (state),
    .path    (path),
    .byp_clr (byp_clr),
    .tdi     (tdi),
    .pad_in  (pad_in),
    .dr_so   (dr_so)
  );

  assign oe_d   = (state == TS_DR_SHIFT) || (state == TS_IR_SHIFT);
  assign so_sel = (state == TS_IR_SHIFT) ? ir_so : dr_so;

  always_ff @(negedge tck or negedge rst_n) begin
    if (!rst_n) begin
      tdo_oe <= 1'b0;
      tdo_q  <= 1'b0;
    end else begin
      tdo_oe <= oe_d;
      if (oe_d) tdo_q <= so_sel;
    end
  end

  assign tdo = tdo_oe ? tdo_q : 1'bz;

  // R8: output enable seen at a rising edge only inside a shift state
  assert_oe_in_shift_R8: assert property (@(posedge tck) disable iff (!rst_n)
    tdo_oe |-> (state == TS_DR_SHIFT || state == TS_IR_SHIFT));

  // R5: pin high impedance only comes with the boundary chain selected
  assert_hiz_on_chain_R5: assert property (@(posedge tck) disable iff (!rst_n)
    dq_hiz |-> path == PATH_BSR);

endmodule

// File: tb/sram_tap_tb.sv
module sram_tap_tb;

  localparam int          W   = 8;
  localparam logic [31:0] IDV = 32'h5A3C_10E1;

  logic         tck = 1'b0;
  logic         por_n, tms, tdi;
  logic [W-1:0] pad_in;
  wire          tdo;
  logic         tdo_oe, dq_hiz;

  int checks = 0;
  int errors = 0;
  string cur_req = "R8";

  // reference model
  int   m_st;
  int   m_ir;
  bit   m_dq[$];
  bit   m_iq[$];

  always #4 tck = ~tck;

  sram_tap #(.BSR_W(W), .ID_VALUE(IDV)) u_dut (
    .tck(tck), .por_n(por_n), .tms(tms), .tdi(tdi), .pad_in(pad_in),
    .tdo(tdo), .tdo_oe(tdo_oe), .dq_hiz(dq_hiz)
  );

  function automatic int nxt(int s, bit m);
    case (s)
      0:  return m ? 0  : 1;
      1:  return m ? 2  : 1;
      2:  return m ? 9  : 3;
      3:  return m ? 5  : 4;
      4:  return m ? 5  : 4;
      5:  return m ? 8  : 6;
      6:  return m ? 7  : 6;
      7:  return m ? 8  : 4;
      8:  return m ? 2  : 1;
      9:  return m ? 0  : 10;
      10: return m ? 12 : 11;
      11: return m ? 12 : 11;
      12: return m ? 15 : 13;
      13: return m ? 14 : 13;
      14: return m ? 15 : 11;
      15: return m ? 2  : 1;
      default: return 0;
    endcase
  endfunction

  task automatic chk(string req, string what, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: got %b expected %b", req, what, act, exp);
    end
  endtask

  task automatic model_rise(bit m, bit d);
    case (m_st)
      0: m_ir = 1;
      3: begin
        m_dq.delete();
        if (m_ir == 0 || m_ir == 2 || m_ir == 4)
          for (int i = 0; i < W; i++) m_dq.push_back(pad_in[i]);
        else if (m_ir == 1)
          for (int i = 0; i < 32; i++) m_dq.push_back(IDV[i]);
        else m_dq.push_back(1'b0);
      end
      4: begin void'(m_dq.pop_front()); m_dq.push_back(d); end
      10: begin m_iq.delete(); m_iq.push_back(1); m_iq.push_back(0); m_iq.push_back(0); end
      11: begin void'(m_iq.pop_front()); m_iq.push_back(d); end
      15: m_ir = m_iq[0] + 2 * m_iq[1] + 4 * m_iq[2];
      default: ;
    endcase
    m_st = nxt(m_st, m);
  endtask

  task automatic step(bit m, bit d);
    bit sh;
    tms = m;
    tdi = d;
    @(posedge tck);
    model_rise(m, d);
    @(negedge tck);
    #1;
    sh = (m_st == 4) || (m_st == 11);
    chk("R8", "tdo_oe", tdo_oe, sh);
    chk("R5", "dq_hiz", dq_hiz, (m_ir == 0 || m_ir == 2));
    if (sh) chk(cur_req, "tdo", tdo, (m_st == 4) ? m_dq[0] : m_iq[0]);
  endtask

  task automatic load_ir(int code);
    string keep = cur_req;
    cur_req = "R3";
    step(1, 0); step(1, 0); step(0, 0); step(0, 0);
    for (int i = 0; i < 3; i++) step(i == 2, code[i]);
    step(1, 0); step(0, 0);
    cur_req = keep;
  endtask

  task automatic scan_dr(int n, logic [63:0] pat);
    step(1, 0); step(0, 0); step(0, 0);
    for (int i = 0; i < n; i++) step(i == n - 1, pat[i % 64]);
    step(1, 0); step(0, 0);
  endtask

  initial begin
    por_n  = 1'b0;
    tms    = 1'b1;
    tdi    = 1'b1;
    pad_in = '0;
    m_st   = 0;
    m_ir   = 1;
    repeat (3) @(negedge tck);
    #1;
    chk("R2", "reset tdo_oe", tdo_oe, 1'b0);
    chk("R2", "reset dq_hiz", dq_hiz, 1'b0);
    por_n = 1'b1;
    repeat (4) step(1, 1);
    step(0, 0);

    // R7: ID word out first, then serial input follows
    cur_req = "R7";
    scan_dr(40, 64'h00C3_9E5B_F00D_1234);

    // R4 / R5 / R6: every code of the map
    for (int c = 0; c < 8; c++) begin
      pad_in  = W'(8'hA5 ^ (c * 37));
      load_ir(c);
      cur_req = (c == 0 || c == 2 || c == 4) ? "R4" : (c == 1) ? "R7" : "R6";
      scan_dr(W + 5, 64'h0000_0000_0000_1B67 ^ c);
    end

    // R1 / R6: bypass kept across pause, then resumed
    load_ir(7);
    cur_req = "R6";
    step(1, 0); step(0, 0); step(0, 0);
    step(0, 1); step(0, 0); step(1, 1);
    step(0, 0); step(0, 0); step(1, 0);
    step(0, 1); step(0, 0); step(1, 0);
    step(1, 0); step(0, 0);

    // R1: IR path through pause and exit2
    cur_req = "R3";
    step(1, 0); step(1, 0); step(0, 0); step(0, 0);
    step(0, 0); step(1, 1);
    step(0, 0); step(1, 0); step(0, 0);
    step(1, 0);
    step(1, 0); step(0, 0);
    cur_req = "R4";
    pad_in = 8'h3C;
    scan_dr(W, 64'h5);

    // R2: five highs from Shift-DR restore IDCODE
    load_ir(4);
    cur_req = "R2";
    step(1, 0); step(0, 0); step(0, 0); step(0, 1);
    repeat (5) step(1, 1);
    chk("R2", "state after five highs", (m_st == 0), 1'b1);
    step(0, 0);
    cur_req = "R2";
    scan_dr(33, 64'h1);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge tck);
    errors++;
    checks++;
    $display("FAIL R1 watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule